// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of up to 64K words by 16 bits, with a separate enable for each byte lane. The host raises a request with an address, a write flag, write data and a two-bit lane mask whenever the controller signals ready. The controller then plays out one complete memory cycle on the active-low chip, write, output and lane enables, and on a split data bus (separate in, out and drive-enable wires). Read results return with a single-clock valid pulse.

Every interval of the memory cycle is a count of clock cycles. Each count is computed at elaboration from a clock-period parameter and a set of nanosecond minimums, always rounded up. A write has a setup cycle, a write-enable pulse and a hold interval. A read holds output enable low for the access time and captures data on the last strobe cycle. A read is always followed by a bus-release gap before the controller can drive the bus again. After reset, a power-up hold-off keeps the memory deselected and the host waiting.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset is released, `rdy` stays low and the chip stays deselected for ceil(T_PWR_NS/CLK_NS) clocks. Requests made during that time are ignored and leave the memory contents unchanged.
- R2: A write is accepted when `req`, `rdy` and `req_we` are high and the mask is non-zero. The controller then gives one setup cycle with chip and lane enables low, then holds write enable low for NWP = ceil(max(35 ns, 25 ns)/CLK_NS) clocks, then gives a hold interval with write enable high. `rdy` is low for 1 + NWP + NWH clocks, where NWH = max(1, ceil(45 ns/CLK_NS) − NWP − 1).
- R3: A read holds chip, output and lane enables low for NRD = ceil(max(45, 22, 45) ns/CLK_NS) clocks, with write enable high throughout. It captures the bus on the last of those cycles, and `rd_valid` appears NRD clocks after acceptance.
- R4: `req_be[0]` selects data bits 7:0 through `mem_lb_n`, and `req_be[1]` selects bits 15:8 through `mem_ub_n`. A write changes only the enabled lanes. In `rd_data`, a lane that was not enabled reads as zero.
- R5: A request whose mask is 2'b00 starts no cycle. `rdy` stays high and the chip stays deselected.
- R6: After every read, the controller spends ceil(18 ns/CLK_NS) clocks with output enable high, chip deselected and its own drivers off, before `rdy` returns.
- R7: Address, lane enables and write data are registered at acceptance and do not change while the chip is selected.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. Write enable and output enable are never low together.
- R9: `rd_valid` is high for exactly one clock per read.
- R10: During reset, all memory strobes are high, `mem_dq_oe` is low and `rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rdy | output | 1 | Controller idle and accepting |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-clock read-data strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
The hardest case to reach is a write issued the moment a read finishes. In that case the bus-release gap is the only thing keeping the two drivers apart. The stimulus reaches it by issuing each write as soon as `rdy` rises after a read, across a sweep that interleaves the two. A cycle-level memory model measures every strobe run and the gap between output enable rising and the controller driving. A second hard case is a request held during the power-up hold-off. The bench drives one there and watches that the chip is never selected and the word stays unwritten.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
package sram_ctrl_pkg;

    localparam int LANE_W  = 8;
    localparam int N_LANES = 2;
    localparam int DATA_W  = LANE_W * N_LANES;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_READ, ST_TURN
    } seq_state_t;

    // Convert a nanosecond minimum to clock cycles, rounding up, never below one.
    function automatic int ns_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwr_holdoff.sv
// Power-up hold-off: counts HOLD_CYC clocks after reset release, then raises pwr_ok.
// Assumes reset is applied while the supply ramps and released once it is stable.
module sram_pwr_holdoff #(
    parameter int HOLD_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_ok
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;

    // Saturating count of clocks since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (cnt != CW'(HOLD_CYC))   cnt <= cnt + 1'b1;
    end

    assign pwr_ok = (cnt == CW'(HOLD_CYC));
endmodule

// File: rtl/sram_req_regs.sv
// Request registers and read capture. Holds address, write data and lane mask
// from acceptance until the next acceptance, and captures read data lane by lane.
module sram_req_regs
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [N_LANES-1:0] req_be,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [N_LANES-1:0] lane_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [N_LANES-1:0] be_q;

    // Latch the request fields at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            be_q       <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            be_q       <= req_be;
        end
    end

    // Lane mask that will be in force after this edge.
    assign lane_sel = accept ? req_be : be_q;

    // One-clock strobe accompanying captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= capture;
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        // Capture an enabled lane from the bus, zero a disabled one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[l*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rd_data[l*LANE_W +: LANE_W] <= be_q[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/sram_seq_fsm.sv
// Cycle sequencer: walks each access through setup, strobe, hold and bus-release
// states using a down counter, and registers every memory strobe so none glitches.
// Assumes all counts are at least one.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int NWP   = 2,
    parameter int NWH   = 1,
    parameter int NRD   = 3,
    parameter int NTURN = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               req,
    input  logic               req_we,
    input  logic [N_LANES-1:0] req_be,
    input  logic [N_LANES-1:0] lane_sel,
    output logic               rdy,
    output logic               accept,
    output logic               capture,
    output logic               mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic               mem_ub_n,
    output logic               mem_lb_n,
    output logic               mem_dq_oe
);
    localparam int MAXC = max2(max2(NWP, NWH), max2(NRD, NTURN));
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state, state_d;
    logic [CW-1:0] cnt, cnt_d;
    logic          active_d, drive_d;

    assign rdy     = pwr_ok && (state == ST_IDLE);
    assign accept  = req && rdy && (|req_be);
    assign capture = (state == ST_READ) && (cnt == '0);

    // Next-state and counter reload decode.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (req_we) state_d = ST_WSETUP;
                else begin
                    state_d = ST_READ;
                    cnt_d   = CW'(NRD - 1);
                end
            end
            ST_WSETUP: begin
                state_d = ST_WPULSE;
                cnt_d   = CW'(NWP - 1);
            end
            ST_WPULSE: if (cnt == '0) begin
                state_d = ST_WHOLD;
                cnt_d   = CW'(NWH - 1);
            end else cnt_d = cnt - 1'b1;
            ST_WHOLD: if (cnt == '0) state_d = ST_IDLE;
                      else           cnt_d   = cnt - 1'b1;
            ST_READ: if (cnt == '0) begin
                state_d = ST_TURN;
                cnt_d   = CW'(NTURN - 1);
            end else cnt_d = cnt - 1'b1;
            ST_TURN: if (cnt == '0) state_d = ST_IDLE;
                     else           cnt_d   = cnt - 1'b1;
            default: state_d = ST_IDLE;
        endcase
    end

    assign active_d = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                      (state_d == ST_WHOLD)  || (state_d == ST_READ);
    assign drive_d  = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                      (state_d == ST_WHOLD);

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // Registered strobes, decoded from the state about to be entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !active_d;
            mem_we_n  <= !(state_d == ST_WPULSE);
            mem_oe_n  <= !(state_d == ST_READ);
            mem_ub_n  <= !(active_d && lane_sel[1]);
            mem_lb_n  <= !(active_d && lane_sel[0]);
            mem_dq_oe <= drive_d;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Top level: host request port to asynchronous SRAM cycles. All intervals are
// clock counts derived from CLK_NS and the nanosecond minimums below.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int ADDR_W      = 16,
    parameter int T_WP_NS     = 35,
    parameter int T_SD_NS     = 25,
    parameter int T_WC_NS     = 45,
    parameter int T_AA_NS     = 45,
    parameter int T_OE_NS     = 22,
    parameter int T_RC_NS     = 45,
    parameter int T_BUSREL_NS = 18,
    parameter int T_PWR_NS    = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rdy,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    input  logic [15:0]       mem_dq_in,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int NWP   = max2(ns_cycles(T_WP_NS, CLK_NS), ns_cycles(T_SD_NS, CLK_NS));
    localparam int NWC   = ns_cycles(T_WC_NS, CLK_NS);
    localparam int NWH   = max2(1, NWC - NWP - 1);
    localparam int NRD   = max2(ns_cycles(T_AA_NS, CLK_NS),
                                max2(ns_cycles(T_OE_NS, CLK_NS), ns_cycles(T_RC_NS, CLK_NS)));
    localparam int NTURN = ns_cycles(T_BUSREL_NS, CLK_NS);
    localparam int NPWR  = ns_cycles(T_PWR_NS, CLK_NS);

    logic              pwr_ok, accept, capture;
    logic [N_LANES-1:0] lane_sel;

    sram_pwr_holdoff #(.HOLD_CYC(NPWR)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok)
    );

    sram_seq_fsm #(.NWP(NWP), .NWH(NWH), .NRD(NRD), .NTURN(NTURN)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .req(req), .req_we(req_we),
        .req_be(req_be), .lane_sel(lane_sel), .rdy(rdy), .accept(accept),
        .capture(capture), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_oe(mem_dq_oe)
    );

    sram_req_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .capture(capture),
        .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .lane_sel(lane_sel), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for sram_async_ctrl, attached by bind. Observes ports only.
module sram_ctrl_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [15:0]       req_wdata,
    input logic [1:0]        req_be,
    input logic              rdy,
    input logic [15:0]       rd_data,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [15:0]       mem_dq_in,
    input logic [15:0]       mem_dq_out,
    input logic              mem_dq_oe
);
    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_oe_we_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    p_accept_drops_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && rdy && (req_be != 2'b00)) |=> !rdy);

    p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && rdy && (req_be == 2'b00)) |=> (rdy && mem_ce_n));

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

    p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && !mem_dq_oe && !rdy));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_lane_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ub_n || !mem_lb_n) |-> !mem_ce_n);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
// Bench: cycle-level memory model with timing monitors, plus a sweep of
// addresses and lane masks checked against a scoreboard.
module tb_sram_async_ctrl;
    localparam int CLK    = 20;
    localparam int AW     = 8;
    localparam int DEPTH  = 1 << AW;
    localparam int PWR_NS = 2000;
    localparam int NPWR_E = (PWR_NS + CLK - 1) / CLK;
    localparam int NWP_E  = (35 + CLK - 1) / CLK;
    localparam int NWH_R  = (45 + CLK - 1) / CLK - NWP_E - 1;
    localparam int NWH_E  = (NWH_R < 1) ? 1 : NWH_R;
    localparam int NRD_E  = (45 + CLK - 1) / CLK;
    localparam int NTR_E  = (18 + CLK - 1) / CLK;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = 2'b00;
    logic rdy, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] rd_data, mem_dq_in, mem_dq_out;
    logic [AW-1:0] mem_addr;

    int checks = 0, fails = 0, viols = 0;
    bit done = 1'b0;
    logic [15:0] mem [DEPTH];
    logic [15:0] sb  [DEPTH];

    always #(CLK/2) clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK), .ADDR_W(AW), .T_PWR_NS(PWR_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rdy(rdy), .rd_data(rd_data),
        .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory read path: enabled lanes only, while selected for reading.
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
        {mem_ub_n ? 8'h00 : mem[mem_addr][15:8], mem_lb_n ? 8'h00 : mem[mem_addr][7:0]} : 16'h0000;

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic viol(input string r, input int act, input int exp);
        viols++;
        chk(r, act, exp);
    endtask

    // Memory model: timing monitors and write commit, sampled at falling edges.
    int we_run = 0, oe_run = 0, oe_hi_run = 100, dat_run = 0;
    logic p_ce = 1, p_we = 1, p_oe = 1, p_ub = 1, p_lb = 1, p_dqoe = 0;
    logic [15:0] p_dq = '0;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) viol("R8 bus contention", 1, 0);
            if (!mem_we_n && !mem_oe_n) viol("R8 we/oe overlap", 1, 0);
            if (!mem_ce_n && !p_ce && (mem_addr != p_addr || mem_ub_n != p_ub || mem_lb_n != p_lb))
                viol("R7 address/lane moved while selected", int'(mem_addr), int'(p_addr));
            if (mem_dq_oe && !p_dqoe && oe_hi_run * CLK < 18)
                viol("R6 drive before bus release (ns)", oe_hi_run * CLK, 18);
            if (p_we == 1'b0 && mem_we_n) begin
                if (we_run * CLK < 35) viol("R2 write pulse ns", we_run * CLK, 35);
                if (dat_run * CLK < 25) viol("R2 data setup ns", dat_run * CLK, 25);
                if (p_ce) viol("R2 write without chip enable", 1, 0);
                if (!p_ub) mem[p_addr][15:8] = p_dq[15:8];
                if (!p_lb) mem[p_addr][7:0]  = p_dq[7:0];
            end
            if (p_oe == 1'b0 && mem_oe_n && oe_run * CLK < 45)
                viol("R3 read strobe ns", oe_run * CLK, 45);
            we_run    = !mem_we_n ? we_run + 1 : 0;
            oe_run    = (!mem_oe_n && !mem_ce_n) ? oe_run + 1 : 0;
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            dat_run   = (mem_dq_oe && (!p_dqoe || mem_dq_out == p_dq)) ? ((p_dqoe) ? dat_run + 1 : 1) : 0;
        end
        p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_ub = mem_ub_n;
        p_lb = mem_lb_n; p_dqoe = mem_dq_oe; p_dq = mem_dq_out; p_addr = mem_addr;
    end

    task automatic wr(input int a, input logic [15:0] d, input logic [1:0] be);
        int low;
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req = 1; req_we = 1; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(negedge clk);
        req = 0;
        low = 0;
        while (!rdy && low < 50) begin low++; @(negedge clk); end
        chk("R2 write busy clocks", low, 1 + NWP_E + NWH_E);
        if (be[1]) sb[a][15:8] = d[15:8];
        if (be[0]) sb[a][7:0]  = d[7:0];
    endtask

    task automatic rd(input int a, input logic [1:0] be);
        int n;
        logic [15:0] exp;
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req = 1; req_we = 0; req_addr = AW'(a); req_be = be;
        @(negedge clk);
        req = 0;
        n = 1;
        while (!rd_valid && n < 50) begin @(negedge clk); n++; end
        chk("R3 read latency", n, NRD_E + 1);
        exp = {be[1] ? sb[a][15:8] : 8'h00, be[0] ? sb[a][7:0] : 8'h00};
        chk("R4 read data per lane", int'(rd_data), int'(exp));
        chk("R6 released at valid", int'({mem_ce_n, mem_dq_oe, mem_oe_n}), 3'b101);
        for (int k = 1; k < NTR_E; k++) @(negedge clk);
        @(negedge clk);
        chk("R9 valid one clock", int'(rd_valid), 0);
    endtask

    function automatic logic [15:0] pat(input int a, input int salt);
        return {8'(a) ^ 8'(8'hA5 + salt), 8'(a) + 8'(8'h3C * (salt + 1))};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int low, ce_seen;
        for (int i = 0; i < DEPTH; i++) begin mem[i] = 16'h0000; sb[i] = 16'h0000; end
        repeat (4) @(negedge clk);
        // R10: reset state of every strobe and of rdy
        chk("R10 reset strobes", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, rdy}), 7'b1111100);
        rst_n = 1;
        // R1: a write held during the hold-off must be ignored
        req = 1; req_we = 1; req_addr = 8'd5; req_wdata = 16'hFFFF; req_be = 2'b11;
        low = 0; ce_seen = 0;
        @(negedge clk);
        while (!rdy && low < 1000) begin
            low++;
            if (!mem_ce_n) ce_seen++;
            if (low == NPWR_E - 3) req = 0;
            @(negedge clk);
        end
        req = 0;
        chk("R1 hold-off clocks", low, NPWR_E - 1);
        chk("R1 no select during hold-off", ce_seen, 0);
        rd(5, 2'b11);
        // R5: zero mask starts nothing
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req = 1; req_we = 1; req_addr = 8'd7; req_wdata = 16'h1234; req_be = 2'b00;
        @(negedge clk);
        req = 0;
        chk("R5 zero mask keeps rdy, deselected", int'({rdy, mem_ce_n}), 2'b11);
        rd(7, 2'b11);
        // R2/R3: full-mask write then read sweep
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0), 2'b11);
        for (int a = 0; a < DEPTH; a++) rd(a, 2'b11);
        // R6: write issued right after a read, alternating
        for (int a = 0; a < 32; a++) begin
            rd(a, 2'b11);
            wr(a, pat(a, 1), 2'b11);
            rd(a, 2'b11);
        end
        // R4: every write mask against every read mask
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, pat(a, 2 + a % 5), 2'((a % 3) + 1));
            rd(a, 2'(((a / 3) % 3) + 1));
        end
        chk("R7 model timing violations", viols, 0);
        done = 1;
        finish_run();
    end
endmodule